// File: doc/BRIEF.md
# Word-Packed Serial Transmitter

This block is the sending half of an asynchronous serial port that software feeds in 32-bit words instead of single bytes. Before each transfer the host writes how many characters the transfer holds. It then pushes data words into a word FIFO. Each word packs up to four characters. The block takes the characters out of each word, lowest byte first, and shifts each one onto the line as a frame with 8 data bits, no parity and 1 stop bit. Bit timing comes from a 16x oversampling enable.

The programmed count alone sets how many characters go out. When the count is not a multiple of four, the unused upper bytes of the last word are thrown away. Words pushed before any count is written stay in the FIFO until a count arrives. Status outputs tell an interrupt or status block the following:

- whether the FIFO can take another word;
- whether the FIFO is empty;
- whether the last character of a transfer has been handed to the shifter. This event is sticky.

A FIFO overflow raises a sticky error. A reset command empties the FIFO and abandons the transfer.

Top module: `wpk_uart_tx`

## Requirements
- R1: Within a word, character k (k = 0..3) sits in bits 8k+7:8k. Characters go out in order of rising k, and a word's characters go out before those of the next word.
- R2: A transfer sends exactly the programmed number of characters. When that number is not a multiple of four, the upper bytes of the final word are discarded. The next transfer starts at byte 0 of the following FIFO word.
- R3: Each character is framed as follows. The line idles at 1. The start bit is 0. The 8 data bits follow, least significant first. The stop bit is 1. Each bit lasts exactly 16 cycles in which `baud_tick` is high.
- R4: `fifo_space` is 1 while the 16-word FIFO holds fewer than 16 words. `fifo_empty` is 1 exactly when the FIFO holds no word.
- R5: A word written while the FIFO is full is dropped and sets `ovf_err`. `ovf_err` stays 1 until a `tx_reset` command, and a finished transfer does not clear it.
- R6: `done_evt` becomes 1 in the cycle after the last character of a transfer is handed to the shifter. It holds until `done_clr` is applied. If set and clear fall in the same cycle, the set wins.
- R7: A count write is ignored while characters of the current transfer remain untaken. A count of 0 starts nothing and raises no `done_evt`.
- R8: `tx_reset` empties the FIFO, drops the remaining count and returns the line to 1 in the next cycle. It does not set `done_evt`. A word written in the same cycle is dropped.
- R9: With no transfer programmed, pushed words stay in the FIFO and nothing is sent.
- R10: After reset, `txd`=1, `fifo_empty`=1, `fifo_space`=1, `done_evt`=0 and `ovf_err`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | 16x oversampling enable |
| cnt_wr | input | 1 | Strobe: load the transfer character count |
| cnt_val | input | CNT_W | Character count for the transfer |
| word_wr | input | 1 | Strobe: push a data word |
| word_data | input | 32 | Data word, up to four characters |
| tx_reset | input | 1 | Command: flush the FIFO and abort the transfer |
| done_clr | input | 1 | Command: clear `done_evt` |
| txd | output | 1 | Serial line out |
| fifo_space | output | 1 | FIFO can accept a word |
| fifo_empty | output | 1 | FIFO holds no word |
| done_evt | output | 1 | Sticky: transfer fully handed off |
| ovf_err | output | 1 | Sticky: a word was dropped on a full FIFO |

## Verification
The transfer-complete set and the software clear of `done_evt` can land in the same cycle. The bench provokes this by holding `done_clr` high through a whole one-character transfer. Because the set has priority, `done_evt` must then show as a pulse exactly one cycle wide; if the clear won, no pulse would appear at all. A second overlap is a count write that lands while a transfer is still running. It is judged at the ports: only the first transfer's characters appear on the line, and the next word stays in the FIFO.

// File: rtl/wpk_pkg.sv
package wpk_pkg;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = 8 * WORD_BYTES;
  localparam int FRAME_BITS = 10;

  // Select character number idx of a packed word.
  function automatic logic [7:0] pick_byte(input logic [WORD_W-1:0] w,
                                           input int unsigned idx);
    return w[idx*8 +: 8];
  endfunction

  // Frame, in shift order from bit 0: start 0, data LSB first, stop 1.
  function automatic logic [FRAME_BITS-1:0] build_frame(input logic [7:0] b);
    return {1'b1, b, 1'b0};
  endfunction

  // Character is the last of its word, or the last of the transfer.
  function automatic logic word_spent(input int unsigned idx,
                                      input logic last_of_xfer);
    return (idx == WORD_BYTES - 1) || last_of_xfer;
  endfunction
endpackage

// File: rtl/wpk_word_fifo.sv
module wpk_word_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         rd,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] level;
  logic          do_wr, do_rd;

  assign full  = (level == CW'(DEPTH));
  assign empty = (level == '0);
  assign do_wr = wr && !full && !flush;
  assign do_rd = rd && !empty && !flush;
  assign rdata = mem[rp];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_wr) wp <= bump(wp);
      if (do_rd) rp <= bump(rp);
      case ({do_wr, do_rd})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/wpk_unpacker.sv
module wpk_unpacker
  import wpk_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              fifo_empty,
  input  logic [WORD_W-1:0] fifo_word,
  input  logic              ser_idle,
  output logic              fifo_pop,
  output logic              byte_take,
  output logic [7:0]        byte_out,
  output logic              last_take,
  output logic [CNT_W-1:0]  remaining
);
  localparam int IW = $clog2(WORD_BYTES);

  logic [WORD_W-1:0] cur_word;
  logic [IW-1:0]     idx;
  logic              have_word;
  logic              cnt_accept;
  logic              pending;

  assign pending    = (remaining != '0);
  assign cnt_accept = cnt_wr && !pending && (cnt_val != '0) && !abort;
  assign fifo_pop   = pending && !have_word && !fifo_empty && !abort;
  assign byte_take  = pending && have_word && ser_idle && !abort;
  assign last_take  = byte_take && (remaining == CNT_W'(1));
  assign byte_out   = pick_byte(cur_word, idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remaining <= '0;
      cur_word  <= '0;
      idx       <= '0;
      have_word <= 1'b0;
    end else if (abort) begin
      remaining <= '0;
      idx       <= '0;
      have_word <= 1'b0;
    end else begin
      if (cnt_accept) remaining <= cnt_val;
      if (fifo_pop) begin
        cur_word  <= fifo_word;
        idx       <= '0;
        have_word <= 1'b1;
      end
      if (byte_take) begin
        remaining <= remaining - 1'b1;
        idx       <= idx + 1'b1;
        if (word_spent(idx, last_take)) have_word <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wpk_serializer.sv
module wpk_serializer
  import wpk_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       abort,
  input  logic       tick,
  input  logic       load,
  input  logic [7:0] din,
  output logic       txd,
  output logic       busy
);
  localparam int TW = (OSR > 1) ? $clog2(OSR) : 1;
  localparam int BW = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] shreg;
  logic [TW-1:0]         tcnt;
  logic [BW-1:0]         bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      shreg <= '1;
      tcnt  <= '0;
      bcnt  <= '0;
    end else if (abort) begin
      busy  <= 1'b0;
      shreg <= '1;
      tcnt  <= '0;
      bcnt  <= '0;
    end else if (!busy) begin
      if (load) begin
        busy  <= 1'b1;
        shreg <= build_frame(din);
        tcnt  <= '0;
        bcnt  <= '0;
      end
    end else if (tick) begin
      if (tcnt == TW'(OSR - 1)) begin
        tcnt <= '0;
        if (bcnt == BW'(FRAME_BITS - 1)) begin
          busy <= 1'b0;
        end else begin
          bcnt  <= bcnt + 1'b1;
          shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
        end
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  assign txd = busy ? shreg[0] : 1'b1;
endmodule

// File: rtl/wpk_uart_tx.sv
module wpk_uart_tx
  import wpk_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = 16,
  parameter int OSR        = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              word_wr,
  input  logic [WORD_W-1:0] word_data,
  input  logic              tx_reset,
  input  logic              done_clr,
  output logic              txd,
  output logic              fifo_space,
  output logic              fifo_empty,
  output logic              done_evt,
  output logic              ovf_err
);
  // Named internal events, also observed by the bound checker.
  logic              fifo_full;
  logic              fifo_pop;
  logic [WORD_W-1:0] fifo_word;
  logic              byte_take;
  logic              last_take;
  logic [7:0]        byte_out;
  logic [CNT_W-1:0]  remaining;
  logic              ser_busy;
  logic              wr_dropped;

  wpk_word_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (tx_reset),
    .wr    (word_wr),
    .wdata (word_data),
    .rd    (fifo_pop),
    .rdata (fifo_word),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  wpk_unpacker #(.CNT_W(CNT_W)) u_unpack (
    .clk        (clk),
    .rst_n      (rst_n),
    .abort      (tx_reset),
    .cnt_wr     (cnt_wr),
    .cnt_val    (cnt_val),
    .fifo_empty (fifo_empty),
    .fifo_word  (fifo_word),
    .ser_idle   (!ser_busy),
    .fifo_pop   (fifo_pop),
    .byte_take  (byte_take),
    .byte_out   (byte_out),
    .last_take  (last_take),
    .remaining  (remaining)
  );

  wpk_serializer #(.OSR(OSR)) u_ser (
    .clk   (clk),
    .rst_n (rst_n),
    .abort (tx_reset),
    .tick  (baud_tick),
    .load  (byte_take),
    .din   (byte_out),
    .txd   (txd),
    .busy  (ser_busy)
  );

  assign fifo_space = !fifo_full;
  assign wr_dropped = word_wr && fifo_full && !tx_reset;

  // Set has priority over the clear command.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         done_evt <= 1'b0;
    else if (last_take) done_evt <= 1'b1;
    else if (done_clr)  done_evt <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ovf_err <= 1'b0;
    else if (tx_reset)   ovf_err <= 1'b0;
    else if (wr_dropped) ovf_err <= 1'b1;
  end
endmodule

// File: rtl/wpk_uart_tx_chk.sv
module wpk_uart_tx_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_reset,
  input logic             word_wr,
  input logic             cnt_wr,
  input logic             done_clr,
  input logic             txd,
  input logic             fifo_space,
  input logic             fifo_empty,
  input logic             done_evt,
  input logic             ovf_err,
  input logic             byte_take,
  input logic             last_take,
  input logic [CNT_W-1:0] remaining,
  input logic             ser_busy
);
  assert_ovf_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_wr && !fifo_space && !tx_reset) |=> ovf_err);

  assert_empty_has_space_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty |-> fifo_space);

  assert_done_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && !done_clr) |=> done_evt);

  assert_done_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    last_take |=> done_evt);

  assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_reset |=> (fifo_empty && txd && (remaining == '0)));

  assert_idle_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_busy |-> txd);

  assert_take_needs_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_take |-> (remaining != '0));

  assert_count_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && (remaining != '0) && !byte_take && !tx_reset)
      |=> (remaining == $past(remaining)));
endmodule

bind wpk_uart_tx wpk_uart_tx_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_reset   (tx_reset),
  .word_wr    (word_wr),
  .cnt_wr     (cnt_wr),
  .done_clr   (done_clr),
  .txd        (txd),
  .fifo_space (fifo_space),
  .fifo_empty (fifo_empty),
  .done_evt   (done_evt),
  .ovf_err    (ovf_err),
  .byte_take  (byte_take),
  .last_take  (last_take),
  .remaining  (remaining),
  .ser_busy   (ser_busy)
);

// File: tb/wpk_uart_tx_bench.sv
module wpk_uart_tx_bench;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             baud_tick = 1'b1;
  logic             cnt_wr = 1'b0;
  logic [CNT_W-1:0] cnt_val = '0;
  logic             word_wr = 1'b0;
  logic [31:0]      word_data = '0;
  logic             tx_reset = 1'b0;
  logic             done_clr = 1'b0;
  logic             txd, fifo_space, fifo_empty, done_evt, ovf_err;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [7:0] rxq[$];
  int frame_bad = 0;

  always #5 clk = ~clk;

  wpk_uart_tx #(.FIFO_DEPTH(16), .CNT_W(CNT_W), .OSR(16)) u_wpk_uart_tx (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .cnt_wr(cnt_wr), .cnt_val(cnt_val),
    .word_wr(word_wr), .word_data(word_data),
    .tx_reset(tx_reset), .done_clr(done_clr),
    .txd(txd), .fifo_space(fifo_space), .fifo_empty(fifo_empty),
    .done_evt(done_evt), .ovf_err(ovf_err)
  );

  // Line receiver: baud_tick is always 1, so one bit is 16 clock cycles.
  initial begin
    logic [7:0] ch;
    forever begin
      @(negedge clk);
      if (rst_n && txd === 1'b0) begin
        repeat (8) @(negedge clk);
        if (txd !== 1'b0) frame_bad++;
        for (int b = 0; b < 8; b++) begin
          repeat (16) @(negedge clk);
          ch[b] = txd;
        end
        repeat (16) @(negedge clk);
        if (txd !== 1'b1) frame_bad++;
        rxq.push_back(ch);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic write_count(input int n);
    @(negedge clk); cnt_wr = 1'b1; cnt_val = CNT_W'(n);
    @(negedge clk); cnt_wr = 1'b0;
  endtask

  task automatic push_word(input logic [31:0] w);
    @(negedge clk); word_wr = 1'b1; word_data = w;
    @(negedge clk); word_wr = 1'b0;
  endtask

  task automatic pulse_clear();
    @(negedge clk); done_clr = 1'b1;
    @(negedge clk); done_clr = 1'b0;
  endtask

  task automatic pulse_reset_cmd();
    @(negedge clk); tx_reset = 1'b1;
    @(negedge clk); tx_reset = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done_evt && n < 20000) begin @(negedge clk); n++; end
    chk(done_evt === 1'b1, req, "done_evt after transfer", done_evt, 1);
  endtask

  // Expected word: character k in byte k; unused bytes filled with noise.
  function automatic logic [31:0] pack_word(input logic [7:0] q[$], input int base);
    logic [31:0] w = '0;
    for (int k = 0; k < 4; k++) begin
      logic [7:0] b = (base + k < q.size()) ? q[base + k] : 8'($urandom);
      w = w | ({24'd0, b} << (8 * k));
    end
    return w;
  endfunction

  task automatic send_transfer(input logic [7:0] q[$]);
    write_count(q.size());
    for (int i = 0; i < (q.size() + 3) / 4; i++) push_word(pack_word(q, 4 * i));
  endtask

  task automatic expect_rx(input logic [7:0] exp[$], input string req);
    chk(rxq.size() == exp.size(), req, "received character count", rxq.size(), exp.size());
    for (int i = 0; i < exp.size() && i < rxq.size(); i++)
      chk(rxq[i] == exp[i], req, $sformatf("character %0d", i), rxq[i], exp[i]);
    chk(frame_bad == 0, "R3", "start/stop bit levels", frame_bad, 0);
    rxq.delete();
    frame_bad = 0;
  endtask

  initial begin
    repeat (250000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] q[$];
    void'($urandom(32'd7321));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    chk(txd === 1'b1, "R10", "txd idle", txd, 1);
    chk(fifo_empty === 1'b1, "R10", "fifo_empty", fifo_empty, 1);
    chk(fifo_space === 1'b1, "R10", "fifo_space", fifo_space, 1);
    chk(done_evt === 1'b0, "R10", "done_evt", done_evt, 0);
    chk(ovf_err === 1'b0, "R10", "ovf_err", ovf_err, 0);

    // R1 R2: five characters, second word only partly valid
    write_count(5);
    push_word(32'h44332211);
    push_word(32'hCCBBAA55);
    wait_done("R6");
    repeat (200) @(negedge clk);
    q = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    expect_rx(q, "R1");
    chk(fifo_empty === 1'b1, "R2", "partial word consumed", fifo_empty, 1);
    chk(done_evt === 1'b1, "R6", "done_evt sticky", done_evt, 1);
    pulse_clear();
    chk(done_evt === 1'b0, "R6", "done_evt cleared", done_evt, 0);

    // R9: words wait for a count
    push_word(32'h0D0C0B0A);
    push_word(32'h1D1C1B1A);
    repeat (300) @(negedge clk);
    chk(rxq.size() == 0, "R9", "nothing sent without count", rxq.size(), 0);
    chk(fifo_empty === 1'b0, "R9", "words kept", fifo_empty, 0);
    write_count(8);
    wait_done("R9");
    repeat (200) @(negedge clk);
    q = '{8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h1A, 8'h1B, 8'h1C, 8'h1D};
    expect_rx(q, "R9");
    pulse_clear();

    // R1 R2 R3: constrained random transfers
    for (int t = 0; t < 6; t++) begin
      int n = 1 + int'($urandom % 12);
      q.delete();
      for (int i = 0; i < n; i++) q.push_back(8'($urandom));
      send_transfer(q);
      wait_done("R6");
      repeat (200) @(negedge clk);
      expect_rx(q, "R2");
      pulse_clear();
    end

    // R7: count write during a transfer is ignored
    write_count(3);
    push_word(32'h77635A4B);
    repeat (40) @(negedge clk);
    write_count(8);
    push_word(32'h11111111);
    wait_done("R7");
    repeat (400) @(negedge clk);
    q = '{8'h4B, 8'h5A, 8'h63};
    expect_rx(q, "R7");
    chk(fifo_empty === 1'b0, "R7", "later word left unsent", fifo_empty, 0);
    pulse_clear();
    write_count(0);
    repeat (300) @(negedge clk);
    chk(rxq.size() == 0, "R7", "zero count sends nothing", rxq.size(), 0);
    chk(done_evt === 1'b0, "R7", "zero count raises no done", done_evt, 0);
    pulse_reset_cmd();
    chk(fifo_empty === 1'b1, "R8", "fifo flushed", fifo_empty, 1);

    // R4 R5: fill, overflow, drain
    q.delete();
    for (int i = 0; i < 64; i++) q.push_back(8'(i * 3 + 1));
    for (int i = 0; i < 16; i++) begin
      push_word(pack_word(q, 4 * i));
      if (i == 14) chk(fifo_space === 1'b1, "R4", "space at 15 words", fifo_space, 1);
    end
    chk(fifo_space === 1'b0, "R4", "no space at 16 words", fifo_space, 0);
    chk(ovf_err === 1'b0, "R5", "no error before overflow", ovf_err, 0);
    push_word(32'hDEADBEEF);
    chk(ovf_err === 1'b1, "R5", "error on full write", ovf_err, 1);
    write_count(64);
    wait_done("R5");
    repeat (200) @(negedge clk);
    expect_rx(q, "R5");
    chk(fifo_empty === 1'b1, "R5", "dropped word absent", fifo_empty, 1);
    chk(ovf_err === 1'b1, "R5", "error sticky", ovf_err, 1);
    pulse_clear();
    pulse_reset_cmd();
    chk(ovf_err === 1'b0, "R5", "error cleared by tx_reset", ovf_err, 0);

    // R8: abort mid-frame
    write_count(8);
    push_word(32'h01020304);
    push_word(32'h05060708);
    repeat (50) @(negedge clk);
    @(negedge clk); tx_reset = 1'b1;
    @(negedge clk); tx_reset = 1'b0;
    chk(txd === 1'b1, "R8", "line high after abort", txd, 1);
    chk(fifo_empty === 1'b1, "R8", "fifo empty after abort", fifo_empty, 1);
    repeat (300) @(negedge clk);
    chk(done_evt === 1'b0, "R8", "no done after abort", done_evt, 0);
    rxq.delete();
    frame_bad = 0;
    write_count(2);
    push_word(32'h9988BEEF);
    wait_done("R8");
    repeat (200) @(negedge clk);
    q = '{8'hEF, 8'hBE};
    expect_rx(q, "R8");
    pulse_clear();

    // R6: set and clear in the same cycle, set wins for one cycle
    begin
      int high = 0;
      @(negedge clk); done_clr = 1'b1;
      write_count(1);
      push_word(32'h0000007E);
      for (int i = 0; i < 400; i++) begin
        @(negedge clk);
        if (done_evt) high++;
      end
      done_clr = 1'b0;
      chk(high == 1, "R6", "done pulse width under held clear", high, 1);
      q = '{8'h7E};
      expect_rx(q, "R6");
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule